// File: doc/BRIEF.md
# Pipelined-Configuration ADC Channel Reader

This block is an SPI master that reads single samples from a 4- or 8-channel successive-approximation converter. The converter acts on a 14-bit configuration word two conversions after that word reaches it. A client raises a request with a channel index. The controller then works out how many configuration frames the converter's two-deep pipeline needs. It shifts those frames out, captures the valid sample in a final frame, and returns the sample with a one-cycle done strobe. Between any two frames it holds chip select high for a programmable idle gap.

The controller keeps a held copy of the configuration word and remembers the channel that was last programmed. When a request names that same channel, one configuration frame is enough. When the channel changes, a second configuration frame is added so that the capture frame returns data converted on the new channel. Capture frames send all zeros, so the overwrite flag is clear and the converter keeps its setting.

After reset the block runs a start-up sequence on its own: it sends an initial word, then performs two discarded reads of channel 0. A register port lets the whole configuration word be read back, or be replaced with a single frame.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy_o is high while the block sends five frames and produces no done strobe. The first frame is the initial word: overwrite bit 13 = 1, input configuration bits 12:10 = 7, channel bits 9:7 = 0, bandwidth bit 6 = 1, reference bits 5:3 = REF_SEL, sequencer bits 2:1 = 0, readback-disable bit 0 = 1. It is followed by configuration-for-channel-0, capture, configuration-for-channel-0, capture. After these frames busy_o falls and cfg_o shows the initial word.
- R2: A read request changes only bits 9:7 of the held configuration, to the requested channel. Every other bit keeps its value.
- R3: A read of a channel that differs from the remembered channel sends two identical configuration frames and then one capture frame. It then pulses done_o with data_o set to the sample converted on the requested channel.
- R4: A read of the remembered channel sends one configuration frame and then the capture frame.
- R5: When a capture completes, the remembered channel becomes the channel that was just read.
- R6: In 16-bit frame mode, a configuration frame carries the 14-bit word in frame bits 15:2 with zeros in bits 1:0, and a capture frame is all zeros. data_o is the received frame shifted right by 16 − RES. In 14-bit mode the word is sent unshifted and data_o is the received frame.
- R7: Chip select stays high for at least GAP_CYCLES clock cycles between the end of one frame and the start of the next.
- R8: During a frame, cs_no is low for exactly FRAME_BITS SCLK pulses. SCLK idles low, MOSI is sent MSB first and changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.
- R9: A read request or register write presented while busy_o is high is ignored. It causes no extra frame or done strobe, and the held configuration does not change.
- R10: A read request with a channel index of NUM_CH or above pulses err_o for one cycle while the block is idle. No frame and no done strobe follow.
- R11: A register write while idle replaces the whole held word, sends it as one configuration frame, and sets the remembered channel to its bits 9:7. cfg_o then reads back the written word. When a read request and a register write arrive together, the read request wins.
- R12: done_o is high for exactly one cycle per completed read, and it is low whenever busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, taken when idle |
| req_ch_i | input | 3 | Requested channel index |
| busy_o | output | 1 | Sequence (start-up, read or register write) in progress |
| done_o | output | 1 | One-cycle strobe, sample valid |
| data_o | output | RES | Raw sample of the last read |
| err_o | output | 1 | One-cycle strobe, channel index out of range |
| reg_wr_i | input | 1 | Overwrite the full configuration word |
| reg_wdata_i | input | 14 | Word written by reg_wr_i |
| cfg_o | output | 14 | Held configuration word |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to the converter |
| miso_i | input | 1 | SPI data from the converter |

## Verification
The bench includes a model of the converter that applies a word only when its overwrite bit is set, and answers each frame with a sample from the channel set two frames earlier. With this model, a design that skipped the second configuration frame on a channel change would return the previous channel's sample. A design that always sent two frames would fail the frame-count check for repeated channels, and one that forgot to update the remembered channel would send the wrong number of frames on the next read. A register write that changes the channel field, followed by reads, shows whether the register path updates the remembered channel and whether later channel changes leave the written bits alone. Requests made during a read, out-of-range indices and the gap before every chip-select fall are also exercised; mishandling them would show up as extra frames, missing error strobes or short gaps.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CFG_W  = 14;
  localparam int CH_LSB = 7;
  localparam int CH_W   = 3;

  typedef enum logic [2:0] {
    ST_INIT, ST_IDLE, ST_CFG_A, ST_CFG_B, ST_CAP, ST_REGW
  } seq_st_e;

  function automatic logic [CFG_W-1:0] init_word(input logic [2:0] ref_sel);
    return {1'b1, 3'd7, 3'd0, 1'b1, ref_sel, 2'd0, 1'b1};
  endfunction
endpackage

// File: rtl/adc_spi_frame.sv
module adc_spi_frame #(
  parameter int FRAME_BITS = 16,
  parameter int CLK_DIV    = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] tx_i,
  input  logic                  miso_i,
  output logic                  sclk_o,
  output logic                  cs_no,
  output logic                  mosi_o,
  output logic                  active_o,
  output logic                  done_o,
  output logic [FRAME_BITS-1:0] rx_o
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] tx_q, rx_q;
  logic [DW-1:0]         cnt_q;
  logic [BW-1:0]         bit_q;
  logic                  act_q, sclk_q, cs_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0; rx_q <= '0; cnt_q <= '0; bit_q <= '0;
      act_q <= 1'b0; sclk_q <= 1'b0; cs_q <= 1'b1; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start_i) begin
          act_q <= 1'b1; cs_q <= 1'b0; tx_q <= tx_i;
          bit_q <= '0; cnt_q <= '0;
        end
      end else if (cnt_q == DIV_LAST) begin
        cnt_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[FRAME_BITS-2:0], miso_i};   // rising edge sample
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == BIT_LAST) begin
            act_q <= 1'b0; cs_q <= 1'b1; done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};    // shift on falling edge
          end
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sclk_o   = sclk_q;
  assign cs_no    = cs_q;
  assign mosi_o   = tx_q[FRAME_BITS-1];
  assign active_o = act_q;
  assign done_o   = done_q;
  assign rx_o     = rx_q;
endmodule

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
  parameter int GAP_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_end_i,
  output logic open_o
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (frame_end_i)      cnt_q <= GW'(GAP_CYCLES);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign open_o = (cnt_q == '0) && !frame_end_i;
endmodule

// File: rtl/adc_word_fmt.sv
module adc_word_fmt #(
  parameter int FRAME_BITS = 16,
  parameter int RES        = 16
) (
  input  logic [13:0]           cfg_i,
  input  logic                  cap_i,
  input  logic [FRAME_BITS-1:0] rx_i,
  output logic [FRAME_BITS-1:0] tx_o,
  output logic [RES-1:0]        data_o
);
  generate
    if (FRAME_BITS == 16) begin : g_wide
      assign tx_o   = cap_i ? '0 : {cfg_i, 2'b00};
      assign data_o = RES'(rx_i >> (16 - RES));
    end else begin : g_narrow
      assign tx_o   = cap_i ? '0 : cfg_i;
      assign data_o = RES'(rx_i);
    end
  endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int RES        = 16,
  parameter int FRAME_BITS = 16,
  parameter int CLK_DIV    = 2,
  parameter int GAP_CYCLES = 200,
  parameter int REF_SEL    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [2:0]       req_ch_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES-1:0]   data_o,
  output logic             err_o,
  input  logic             reg_wr_i,
  input  logic [13:0]      reg_wdata_i,
  output logic [13:0]      cfg_o,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             mosi_o,
  input  logic             miso_i
);
  localparam logic [CFG_W-1:0] INIT_CFG = init_word(3'(REF_SEL));

  seq_st_e               st_q;
  logic [CFG_W-1:0]      cfg_q;
  logic [CH_W-1:0]       cur_q, tgt_q;
  logic [1:0]            dummy_q;
  logic                  quiet_q, launched_q, done_q, err_q;
  logic [RES-1:0]        data_q;

  logic                  launch, eng_active, eng_done, gap_open;
  logic [FRAME_BITS-1:0] tx_word, rx_word;
  logic [RES-1:0]        rx_data;

  adc_spi_frame #(.FRAME_BITS(FRAME_BITS), .CLK_DIV(CLK_DIV)) u_frame (
    .clk_i, .rst_ni, .start_i(launch), .tx_i(tx_word), .miso_i,
    .sclk_o, .cs_no, .mosi_o, .active_o(eng_active), .done_o(eng_done),
    .rx_o(rx_word)
  );

  adc_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i, .rst_ni, .frame_end_i(eng_done), .open_o(gap_open)
  );

  adc_word_fmt #(.FRAME_BITS(FRAME_BITS), .RES(RES)) u_fmt (
    .cfg_i(cfg_q), .cap_i(st_q == ST_CAP), .rx_i(rx_word),
    .tx_o(tx_word), .data_o(rx_data)
  );

  assign launch = (st_q != ST_IDLE) && !launched_q && gap_open && !eng_active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_INIT; cfg_q <= INIT_CFG; cur_q <= '0; tgt_q <= '0;
      dummy_q <= '0; quiet_q <= 1'b0; launched_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; data_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (launch) launched_q <= 1'b1;
      if (st_q == ST_IDLE) begin
        if (req_i) begin
          if (int'(req_ch_i) < NUM_CH) begin
            tgt_q <= req_ch_i;
            cfg_q[CH_LSB +: CH_W] <= req_ch_i;
            st_q <= ST_CFG_A;
          end else begin
            err_q <= 1'b1;
          end
        end else if (reg_wr_i) begin
          cfg_q <= reg_wdata_i;
          cur_q <= reg_wdata_i[CH_LSB +: CH_W];
          st_q  <= ST_REGW;
        end
      end else if (eng_done) begin
        launched_q <= 1'b0;
        unique case (st_q)
          ST_INIT: begin
            tgt_q <= '0; quiet_q <= 1'b1; dummy_q <= 2'd2; st_q <= ST_CFG_A;
          end
          ST_CFG_A: st_q <= (tgt_q != cur_q) ? ST_CFG_B : ST_CAP;
          ST_CFG_B: st_q <= ST_CAP;
          ST_CAP: begin
            cur_q <= tgt_q;
            if (quiet_q) begin
              if (dummy_q == 2'd1) begin
                quiet_q <= 1'b0; st_q <= ST_IDLE;
              end else begin
                dummy_q <= dummy_q - 1'b1; st_q <= ST_CFG_A;
              end
            end else begin
              done_q <= 1'b1; data_q <= rx_data; st_q <= ST_IDLE;
            end
          end
          ST_REGW: st_q <= ST_IDLE;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
  assign data_o = data_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int GAP_CYCLES = 200
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_no,
  input logic        sclk_o,
  input logic        mosi_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic        reg_wr_i,
  input logic [13:0] cfg_o
);
  logic [31:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       hi_q <= 32'(GAP_CYCLES);
    else if (!cs_no)                   hi_q <= '0;
    else if (hi_q < 32'(GAP_CYCLES))   hi_q <= hi_q + 1;
  end

  a_r8_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  a_r8_mosi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));
  a_r7_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> hi_q >= 32'(GAP_CYCLES));
  a_r2_cfg_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reg_wr_i) |-> $stable({cfg_o[13:10], cfg_o[6:0]}));
  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r12_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r10_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !done_o));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_no(cs_no), .sclk_o(sclk_o),
  .mosi_o(mosi_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .reg_wr_i(reg_wr_i), .cfg_o(cfg_o)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int NCH = 4;
  localparam int GAP = 200;
  localparam int REFS = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, reg_wr = 1'b0, miso = 1'b0;
  logic [2:0] req_ch = '0;
  logic [13:0] wdata = '0;
  logic busy, done, err, sclk, cs_n, mosi;
  logic [15:0] data;
  logic [13:0] cfg;

  int vectors = 0, fails = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl #(.NUM_CH(NCH), .RES(16), .FRAME_BITS(16), .CLK_DIV(2),
                 .GAP_CYCLES(GAP), .REF_SEL(REFS)) u_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_ch_i(req_ch),
    .busy_o(busy), .done_o(done), .data_o(data), .err_o(err),
    .reg_wr_i(reg_wr), .reg_wdata_i(wdata), .cfg_o(cfg),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sample(input logic [2:0] c);
    return 16'h0C35 + 16'(c) * 16'h1357;
  endfunction

  // reference state
  logic [15:0] exp_q[$];
  logic [13:0] mcfg;
  logic [2:0]  mcur;
  bit          allow_done = 0;
  int          frames = 0;

  // converter model: applies a word only with overwrite set, answers from two frames back
  logic [15:0] s_rx, s_tx;
  logic [13:0] held = '0, h1 = '0, h2 = '0;
  int          s_idx;

  always @(negedge cs_n) if (rst_n) begin
    s_tx = sample(h2[9:7]); s_idx = 0; miso = s_tx[15]; s_rx = '0;
  end
  always @(negedge sclk) if (rst_n && !cs_n) begin
    s_idx++;
    if (s_idx < 16) miso = s_tx[15 - s_idx];
  end
  always @(posedge sclk) if (rst_n && !cs_n) s_rx = {s_rx[14:0], mosi};
  always @(posedge cs_n) if (rst_n) begin
    frames++;
    if (exp_q.size() == 0) chk(0, "R9 unexpected frame", s_rx, 0);
    else begin
      logic [15:0] e;
      e = exp_q.pop_front();
      chk(s_rx == e, "R6 frame word", s_rx, e);
    end
    if (s_rx[15]) held = s_rx[15:2];
    h2 = h1; h1 = held;
  end

  // per-clock reference comparison
  int  hi = 1000000;
  bit  cs_prev = 1;
  always @(negedge clk) if (rst_n) begin
    chk(!(cs_n && sclk), "R8 sclk idle low", sclk, 0);
    if (cs_n) hi++;
    else begin
      if (cs_prev) chk(hi >= GAP, "R7 idle gap", hi, GAP);
      hi = 0;
    end
    cs_prev = cs_n;
    if (done && !allow_done) chk(0, "R12 stray done", done, 0);
    if (done) chk(!busy, "R12 done while busy", busy, 0);
  end

  task automatic wait_idle();
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic do_read(input logic [2:0] c, input bit intrude, input string tag);
    logic [13:0] cfg_before;
    bit seen = 0;
    wait_idle();
    mcfg[9:7] = c;
    exp_q.push_back({mcfg, 2'b00});
    if (c != mcur) exp_q.push_back({mcfg, 2'b00});
    exp_q.push_back(16'h0000);
    allow_done = 1;
    req = 1; req_ch = c;
    @(negedge clk); req = 0;
    cfg_before = mcfg;
    if (intrude) begin
      repeat (100) @(negedge clk);
      req = 1; req_ch = 3'((c + 1) % NCH); reg_wr = 1; wdata = 14'h0155;
      @(negedge clk); req = 0; reg_wr = 0;
    end
    for (int n = 0; n < 20000; n++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, tag, seen, 1);
    chk(data == sample(c), tag, data, sample(c));
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    @(negedge clk);
    chk(!done, "R12 done width", done, 0);
    allow_done = 0;
    mcur = c;
    chk(cfg == mcfg, "R2 held word", cfg, mcfg);
    if (intrude) begin
      repeat (600) @(negedge clk);
      chk(!busy && exp_q.size() == 0, "R9 request while busy", busy, 0);
      chk(cfg == cfg_before, "R9 cfg untouched", cfg, cfg_before);
    end
  endtask

  task automatic bad_read(input logic [2:0] c);
    int f0;
    wait_idle();
    f0 = frames;
    req = 1; req_ch = c;
    @(negedge clk); req = 0;
    chk(err == 1'b1, "R10 err strobe", err, 1);
    chk(!busy, "R10 stays idle", busy, 0);
    @(negedge clk);
    chk(err == 1'b0, "R10 err width", err, 0);
    repeat (300) @(negedge clk);
    chk(frames == f0, "R10 no frame", frames, f0);
  endtask

  task automatic reg_write(input logic [13:0] w);
    wait_idle();
    exp_q.push_back({w, 2'b00});
    mcfg = w; mcur = w[9:7];
    reg_wr = 1; wdata = w;
    @(negedge clk); reg_wr = 0;
    chk(busy, "R11 busy on write", busy, 1);
    wait_idle();
    chk(cfg == w, "R11 readback", cfg, w);
    chk(exp_q.size() == 0, "R11 one frame", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [13:0] iw;
    iw = {1'b1, 3'd7, 3'd0, 1'b1, 3'(REFS), 2'd0, 1'b1};
    mcfg = iw; mcur = 3'd0;
    exp_q.push_back({iw, 2'b00});
    exp_q.push_back({iw, 2'b00});
    exp_q.push_back(16'h0000);
    exp_q.push_back({iw, 2'b00});
    exp_q.push_back(16'h0000);
    repeat (4) @(negedge clk);
    chk(cs_n && !sclk && !done && !err, "R1 reset outputs", {cs_n, sclk, done, err}, 4'b1000);
    chk(busy, "R1 busy in reset", busy, 1);
    chk(cfg == iw, "R1 initial word", cfg, iw);
    rst_n = 1;
    @(negedge clk);
    chk(busy, "R1 busy during start-up", busy, 1);
    wait_idle();
    chk(exp_q.size() == 0 && frames == 5, "R1 start-up frames", frames, 5);
    chk(cfg == iw, "R1 cfg after start-up", cfg, iw);

    do_read(3'd0, 0, "R4 same channel read");
    do_read(3'd3, 0, "R3 channel change read");
    do_read(3'd3, 0, "R5 remembered channel");
    do_read(3'd1, 0, "R3 change to 1");
    do_read(3'd2, 1, "R9 read with intrusion");
    bad_read(3'd6);
    bad_read(3'd4);
    reg_write({1'b1, 3'b011, 3'd2, 1'b0, 3'b110, 2'b10, 1'b1});
    do_read(3'd2, 0, "R11 channel from write");
    do_read(3'd1, 0, "R2 only channel field");
    do_read(3'd0, 0, "R3 back to 0");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule